// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns one core-side memory request into transfers on a shared 16-bit external bus that carries both address and data. Each transfer has an address phase and then a strobe phase. During the address phase the block drives the address onto the shared lines and pulses the address strobe. During the strobe phase it either drives the write data or releases the lines and captures the read data. A slow device can stretch the strobe phase with a ready input, up to a configured limit. The width of each access is taken from a pin when a control input allows it. On an 8-bit bus a word access becomes two byte transfers.

The requester holds its request fields stable while `req_valid` is high. The block answers with a one-clock `req_done` pulse, and read data appears on `req_rdata` in the same clock as that pulse. The requester must drop or change `req_valid` before the next clock edge.

Three configuration inputs select how the pins behave. The address strobe can be a short latch pulse or a valid level that covers the whole transfer. The write strobes can be one common strobe plus a high-byte enable, or one strobe for each byte lane. An external master can also take the bus through a hold/acknowledge handshake. While the bus is held, a request output tells that master that the core is waiting for the bus.

Top module: `mxbus_ctrl`

## Requirements
- R1: After reset the block is idle. `pin_rd_n`, `pin_wr_n` and `pin_bhe_n` are 1. `pin_ad_oe`, `pin_inst`, `pin_hlda`, `pin_breq` and `req_done` are 0. `pin_ctl_oe` is 1. `pin_astb` is 0 in latch mode and 1 in valid-level mode.
- R2: An accepted request spends one clock in the address phase and then at least one clock in the strobe phase. During the address phase `pin_ad_o` carries the transfer address with `pin_ad_oe`=1. `req_done` pulses in the clock after the last strobe phase.
- R3: Bus width is sampled from `pin_buswidth` in the first address phase of an access, but only when `cfg_dyn_width`=1 (pin 1 gives 16-bit, pin 0 gives 8-bit). When `cfg_dyn_width`=0 every access is 8-bit.
- R4: With `cfg_split_wr`=0, `pin_bhe_n` is low in both phases of a transfer whose address is odd, and of the first transfer of a word. It is high otherwise. So the low byte alone gives A0=0 with bhe 1, the high byte alone gives A0=1 with bhe 0, and both bytes give A0=0 with bhe 0. In this mode `pin_wr_n` is low during the strobe phase of every write.
- R5: With `cfg_split_wr`=1, `pin_wr_n` (low-lane strobe) goes low in the strobe phase only for writes at an even address. `pin_bhe_n` (high-lane strobe) goes low only for writes at an odd address, or for a word written on a 16-bit bus. Both pins stay high for reads.
- R6: The strobe phase ends on the first clock edge where `pin_ready`=1, or on the edge after `cfg_max_wait` wait clocks, whichever comes first.
- R7: With `cfg_adv_mode`=0, `pin_astb` is high only in the address phase. With `cfg_adv_mode`=1, `pin_astb` is low through the address and strobe phases and high between transfers.
- R8: `pin_inst` is high in both phases of a read whose `req_fetch`=1, and low in every other clock.
- R9: With `cfg_hold_en`=1, a high `pin_hold` seen while idle raises `pin_hlda` in the next clock. While `pin_hlda` is high, `pin_ad_oe` and `pin_ctl_oe` are 0 and `pin_breq` equals `req_valid`. Releasing `pin_hold` lowers `pin_hlda` and restores `pin_ctl_oe` in the next clock. With `cfg_hold_en`=0, `pin_hold` is ignored and `pin_hlda` and `pin_breq` stay 0.
- R10: A hold request that arrives during an access is granted only after that access has completed. `pin_hlda` is high in the clock after the `req_done` pulse.
- R11: On an 8-bit bus a word access runs as two byte transfers back to back: the even address with the low byte first, then the odd address with the high byte. The read result is {second byte, first byte}, both taken from `pin_ad_i[7:0]`.
- R12: On a 16-bit bus a word read returns `pin_ad_i` unchanged. A byte read returns `pin_ad_i[15:8]` for an odd address and `pin_ad_i[7:0]` for an even address, with the upper result byte set to 0. On an 8-bit bus a byte read always uses `pin_ad_i[7:0]`.
- R13: During the strobe phase of a write, `pin_ad_oe`=1. A word on a 16-bit bus appears on `pin_ad_o` as is. Any byte transfer places its byte on both lanes of `pin_ad_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dyn_width | input | 1 | 1: bus width taken from pin_buswidth per access |
| cfg_split_wr | input | 1 | 1: separate low/high write strobes |
| cfg_adv_mode | input | 1 | 1: address strobe is a whole-transfer valid level |
| cfg_hold_en | input | 1 | 1: hold handshake active |
| cfg_max_wait | input | WAIT_W | Upper bound on wait clocks per transfer |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Byte address (bit 0 ignored for words) |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_word | input | 1 | 1: word access, 0: byte access |
| req_write | input | 1 | 1: write, 0: read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read result, valid with req_done |
| pin_ad_i | input | 16 | Shared bus lines as seen at the pins |
| pin_ad_o | output | 16 | Shared bus value driven by the block |
| pin_ad_oe | output | 1 | Drive enable for pin_ad_o |
| pin_astb | output | 1 | Address latch pulse or address-valid level |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_wr_n | output | 1 | Write strobe or low-lane write strobe, active low |
| pin_bhe_n | output | 1 | High-byte enable or high-lane write strobe, active low |
| pin_inst | output | 1 | Instruction-fetch indicator |
| pin_ctl_oe | output | 1 | Drive enable for rd, wr, bhe and inst pins |
| pin_ready | input | 1 | Device ready; low stretches the strobe phase |
| pin_buswidth | input | 1 | Per-access width select |
| pin_hold | input | 1 | External master asks for the bus |
| pin_hlda | output | 1 | Bus handed over |
| pin_breq | output | 1 | Core has a pending access while the bus is held |

## Verification
The bench uses the default `WAIT_W`=3, so the wait limit can be set anywhere from 0 to 7. Every combination of width mode, width pin, strobe mode, strobe style, size, direction, address parity and fetch flag is run, with 0 to 2 wait clocks before ready. This covers every BHE code, every strobe combination and every lane-steering case, including word splitting on an 8-bit bus. A second sweep sets the wait limit from 0 to 2 and holds ready low past it, so that the limit itself ends the stretch. Hold is tested three ways: granted while idle with a request pending, ignored while disabled, and raised during a stretched access.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  localparam int BUS_W   = 16;
  localparam int LANE_W  = 8;
  localparam int N_LANES = BUS_W / LANE_W;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_HELD} phase_e;

  // Byte driven on one lane of a write transfer.
  function automatic logic [LANE_W-1:0] lane_wbyte(
    input logic [BUS_W-1:0] w,
    input logic             full,
    input logic             second,
    input int               lane
  );
    if (full) return w[lane*LANE_W +: LANE_W];
    return second ? w[BUS_W-1 -: LANE_W] : w[LANE_W-1:0];
  endfunction

  // Read result assembled at the end of the last transfer of an access.
  function automatic logic [BUS_W-1:0] join_rdata(
    input logic              word,
    input logic              bus16,
    input logic              odd,
    input logic [BUS_W-1:0]  ad,
    input logic [LANE_W-1:0] low
  );
    if (word) return bus16 ? ad : {ad[LANE_W-1:0], low};
    return {{(BUS_W-LANE_W){1'b0}},
            (bus16 && odd) ? ad[BUS_W-1 -: LANE_W] : ad[LANE_W-1:0]};
  endfunction
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dyn_width,
  input  logic              cfg_hold_en,
  input  logic [WAIT_W-1:0] cfg_max_wait,
  input  logic              req_valid,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              pin_ready,
  input  logic              pin_buswidth,
  input  logic              pin_hold,
  output phase_e            ph_q,
  output logic [BUS_W-1:0]  addr_q,
  output logic [BUS_W-1:0]  wdata_q,
  output logic              word_q,
  output logic              write_q,
  output logic              fetch_q,
  output logic              second_q,
  output logic              bus16_q,
  output logic              done_q,
  output logic [WAIT_W-1:0] wait_q,
  output logic              ev_split,
  output logic              ev_last
);
  logic ev_grant, ev_start, ev_cyc_end;

  assign ev_grant   = (ph_q == PH_IDLE) && cfg_hold_en && pin_hold;
  assign ev_start   = (ph_q == PH_IDLE) && !ev_grant && req_valid && !done_q;
  assign ev_cyc_end = (ph_q == PH_DATA) && (pin_ready || (wait_q == cfg_max_wait));
  assign ev_split   = ev_cyc_end && word_q && !bus16_q && !second_q;
  assign ev_last    = ev_cyc_end && !ev_split;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      word_q   <= 1'b0;
      write_q  <= 1'b0;
      fetch_q  <= 1'b0;
      second_q <= 1'b0;
      bus16_q  <= 1'b0;
      done_q   <= 1'b0;
      wait_q   <= '0;
    end else begin
      done_q <= ev_last;
      unique case (ph_q)
        PH_IDLE: begin
          if (ev_grant) begin
            ph_q <= PH_HELD;
          end else if (ev_start) begin
            ph_q     <= PH_ADDR;
            addr_q   <= req_word ? {req_addr[BUS_W-1:1], 1'b0} : req_addr;
            wdata_q  <= req_wdata;
            word_q   <= req_word;
            write_q  <= req_write;
            fetch_q  <= req_fetch;
            second_q <= 1'b0;
          end
        end
        PH_ADDR: begin
          ph_q   <= PH_DATA;
          wait_q <= '0;
          if (!second_q) bus16_q <= cfg_dyn_width & pin_buswidth;
        end
        PH_DATA: begin
          if (ev_split) begin
            ph_q      <= PH_ADDR;
            second_q  <= 1'b1;
            addr_q[0] <= 1'b1;
          end else if (ev_last) begin
            ph_q <= PH_IDLE;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        PH_HELD: begin
          if (!pin_hold || !cfg_hold_en) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mxbus_pins.sv
module mxbus_pins
  import mxbus_pkg::*;
(
  input  phase_e           ph,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             word,
  input  logic             second,
  input  logic             write,
  input  logic             fetch,
  input  logic             bus16,
  input  logic             cfg_split_wr,
  input  logic             cfg_adv_mode,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe,
  output logic             astb,
  output logic             rd_n,
  output logic             wr_n,
  output logic             bhe_n,
  output logic             inst,
  output logic             ctl_oe,
  output logic             hlda
);
  logic in_addr, in_data, in_xfer, odd, incl_hi, lane_hi, lane_lo;
  logic [BUS_W-1:0] wr_lanes;

  assign in_addr = (ph == PH_ADDR);
  assign in_data = (ph == PH_DATA);
  assign in_xfer = in_addr || in_data;
  assign odd     = addr[0];
  assign incl_hi = odd || (word && !second);
  assign lane_hi = odd || (word && bus16);
  assign lane_lo = !odd;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign wr_lanes[l*LANE_W +: LANE_W] = lane_wbyte(wdata, word && bus16, second, l);
  end

  always_comb begin
    ad_o   = in_addr ? addr : wr_lanes;
    ad_oe  = in_addr || (in_data && write);
    astb   = cfg_adv_mode ? !in_xfer : in_addr;
    rd_n   = !(in_data && !write);
    wr_n   = cfg_split_wr ? !(in_data && write && lane_lo) : !(in_data && write);
    bhe_n  = cfg_split_wr ? !(in_data && write && lane_hi) : !(in_xfer && incl_hi);
    inst   = in_xfer && fetch && !write;
    ctl_oe = (ph != PH_HELD);
    hlda   = (ph == PH_HELD);
  end
endmodule

// File: rtl/mxbus_rcap.sv
module mxbus_rcap
  import mxbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_split,
  input  logic             ev_last,
  input  logic             word,
  input  logic             bus16,
  input  logic             odd,
  input  logic [BUS_W-1:0] pin_ad_i,
  output logic [BUS_W-1:0] rdata_q
);
  logic [LANE_W-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (ev_split) low_q <= pin_ad_i[LANE_W-1:0];
      if (ev_last)  rdata_q <= join_rdata(word, bus16, odd, pin_ad_i, low_q);
    end
  end
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dyn_width,
  input  logic              cfg_split_wr,
  input  logic              cfg_adv_mode,
  input  logic              cfg_hold_en,
  input  logic [WAIT_W-1:0] cfg_max_wait,
  input  logic              req_valid,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              req_done,
  output logic [15:0]       req_rdata,
  input  logic [15:0]       pin_ad_i,
  output logic [15:0]       pin_ad_o,
  output logic              pin_ad_oe,
  output logic              pin_astb,
  output logic              pin_rd_n,
  output logic              pin_wr_n,
  output logic              pin_bhe_n,
  output logic              pin_inst,
  output logic              pin_ctl_oe,
  input  logic              pin_ready,
  input  logic              pin_buswidth,
  input  logic              pin_hold,
  output logic              pin_hlda,
  output logic              pin_breq
);
  phase_e            ph_q;
  logic [BUS_W-1:0]  addr_q, wdata_q;
  logic              word_q, write_q, fetch_q, second_q, bus16_q, done_q;
  logic [WAIT_W-1:0] wait_q;
  logic              ev_split, ev_last;
  logic              ph_is_data;

  mxbus_seq #(.WAIT_W(WAIT_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .cfg_dyn_width(cfg_dyn_width), .cfg_hold_en(cfg_hold_en),
    .cfg_max_wait(cfg_max_wait), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_word(req_word), .req_write(req_write), .req_fetch(req_fetch),
    .pin_ready(pin_ready), .pin_buswidth(pin_buswidth), .pin_hold(pin_hold),
    .ph_q(ph_q), .addr_q(addr_q), .wdata_q(wdata_q), .word_q(word_q), .write_q(write_q),
    .fetch_q(fetch_q), .second_q(second_q), .bus16_q(bus16_q), .done_q(done_q),
    .wait_q(wait_q), .ev_split(ev_split), .ev_last(ev_last)
  );

  mxbus_pins i_pins (
    .ph(ph_q), .addr(addr_q), .wdata(wdata_q), .word(word_q), .second(second_q),
    .write(write_q), .fetch(fetch_q), .bus16(bus16_q), .cfg_split_wr(cfg_split_wr),
    .cfg_adv_mode(cfg_adv_mode), .ad_o(pin_ad_o), .ad_oe(pin_ad_oe), .astb(pin_astb),
    .rd_n(pin_rd_n), .wr_n(pin_wr_n), .bhe_n(pin_bhe_n), .inst(pin_inst),
    .ctl_oe(pin_ctl_oe), .hlda(pin_hlda)
  );

  mxbus_rcap i_rcap (
    .clk(clk), .rst_n(rst_n), .ev_split(ev_split), .ev_last(ev_last), .word(word_q),
    .bus16(bus16_q), .odd(addr_q[0]), .pin_ad_i(pin_ad_i), .rdata_q(req_rdata)
  );

  assign req_done   = done_q;
  assign pin_breq   = pin_hlda && cfg_hold_en && req_valid;
  assign ph_is_data = (ph_q == PH_DATA);
endmodule

// File: rtl/mxbus_ctrl_chk.sv
module mxbus_ctrl_chk #(
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_hold_en,
  input logic              cfg_adv_mode,
  input logic [WAIT_W-1:0] cfg_max_wait,
  input logic              req_done,
  input logic              pin_ad_oe,
  input logic              pin_astb,
  input logic              pin_rd_n,
  input logic              pin_wr_n,
  input logic              pin_inst,
  input logic              pin_ctl_oe,
  input logic              pin_hlda,
  input logic              pin_breq,
  input logic              ph_is_data,
  input logic [WAIT_W-1:0] wait_q,
  input logic              second_q,
  input logic              odd
);
  a_r9_float_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hlda |-> (!pin_ad_oe && !pin_ctl_oe));

  a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hold_en |=> (!pin_hlda && !pin_breq));

  a_r10_grant_between_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_hlda) |-> $past(pin_rd_n && pin_wr_n && !pin_ad_oe));

  a_r2_read_after_address: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_rd_n) |-> $past(pin_ad_oe));

  a_r2_done_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ph_is_data |-> (wait_q <= cfg_max_wait));

  a_r8_inst_not_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    pin_inst |-> pin_wr_n);

  a_r11_second_is_odd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_q) |-> odd);

  a_r7_latch_pulse_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv_mode && pin_astb) |-> (pin_rd_n && pin_wr_n && pin_ad_oe));

  a_r5_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pin_rd_n && !pin_wr_n));
endmodule

bind mxbus_ctrl mxbus_ctrl_chk #(.WAIT_W(WAIT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hold_en(cfg_hold_en), .cfg_adv_mode(cfg_adv_mode),
  .cfg_max_wait(cfg_max_wait), .req_done(req_done), .pin_ad_oe(pin_ad_oe),
  .pin_astb(pin_astb), .pin_rd_n(pin_rd_n), .pin_wr_n(pin_wr_n), .pin_inst(pin_inst),
  .pin_ctl_oe(pin_ctl_oe), .pin_hlda(pin_hlda), .pin_breq(pin_breq),
  .ph_is_data(ph_is_data), .wait_q(wait_q), .second_q(second_q), .odd(addr_q[0])
);

// File: tb/test_mxbus_ctrl.sv
module test_mxbus_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dyn_width = 0, cfg_split_wr = 0, cfg_adv_mode = 0, cfg_hold_en = 0;
  logic [2:0] cfg_max_wait = 3'd3;
  logic req_valid = 0, req_word = 0, req_write = 0, req_fetch = 0;
  logic [15:0] req_addr = '0, req_wdata = '0, pin_ad_i = '0;
  logic pin_ready = 1, pin_buswidth = 0, pin_hold = 0;
  logic req_done, pin_ad_oe, pin_astb, pin_rd_n, pin_wr_n, pin_bhe_n, pin_inst;
  logic pin_ctl_oe, pin_hlda, pin_breq;
  logic [15:0] req_rdata, pin_ad_o;
  int checks = 0, failures = 0, txn = 0;

  always #4 clk = ~clk;

  mxbus_ctrl #(.WAIT_W(3)) i_mxbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dyn_width(cfg_dyn_width), .cfg_split_wr(cfg_split_wr),
    .cfg_adv_mode(cfg_adv_mode), .cfg_hold_en(cfg_hold_en), .cfg_max_wait(cfg_max_wait),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata), .req_word(req_word),
    .req_write(req_write), .req_fetch(req_fetch), .req_done(req_done), .req_rdata(req_rdata),
    .pin_ad_i(pin_ad_i), .pin_ad_o(pin_ad_o), .pin_ad_oe(pin_ad_oe), .pin_astb(pin_astb),
    .pin_rd_n(pin_rd_n), .pin_wr_n(pin_wr_n), .pin_bhe_n(pin_bhe_n), .pin_inst(pin_inst),
    .pin_ctl_oe(pin_ctl_oe), .pin_ready(pin_ready), .pin_buswidth(pin_buswidth),
    .pin_hold(pin_hold), .pin_hlda(pin_hlda), .pin_breq(pin_breq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s txn=%0d act=%h exp=%h", tag, txn, act, exp);
    end
  endtask

  // {astb, rd_n, wr_n, bhe_n, inst, ad_oe, ctl_oe, hlda, done}
  function automatic logic [8:0] pins();
    return {pin_astb, pin_rd_n, pin_wr_n, pin_bhe_n, pin_inst, pin_ad_oe,
            pin_ctl_oe, pin_hlda, req_done};
  endfunction

  task automatic do_access(input bit dyn, input bit bw, input bit split, input bit adv,
                           input bit word, input bit wr, input bit a0, input bit fetch,
                           input int d, input int maxw, input bit hmid,
                           input logic [15:0] base);
    bit bus16, odd, incl_hi, lhi, llo, fin;
    int ncyc, j;
    logic [15:0] caddr, pat0, pat1, exp_rd, exp_ad;
    logic [7:0] b;
    txn++;
    bus16 = dyn && bw;
    ncyc  = (word && !bus16) ? 2 : 1;
    pat0  = {8'hC3 ^ txn[7:0], 8'h1E + txn[7:0]};
    pat1  = {8'h69, 8'hB4 ^ txn[7:0]};
    @(negedge clk);
    cfg_dyn_width = dyn; cfg_split_wr = split; cfg_adv_mode = adv; cfg_max_wait = maxw[2:0];
    req_valid = 1; req_word = word; req_write = wr; req_fetch = fetch;
    req_addr = {base[15:1], a0}; req_wdata = {8'hA0 ^ txn[7:0], 8'h5F + txn[7:0]};
    pin_ready = 1;
    @(negedge clk);
    for (int k = 0; k < ncyc; k++) begin
      caddr = word ? {base[15:1], k[0]} : {base[15:1], a0};
      odd = caddr[0];
      incl_hi = odd || (word && k == 0);
      lhi = odd || (word && bus16);
      llo = !odd;
      // address phase: R2 R4 R7 R8
      chk("R2 R4 R7 R8 address-phase pins", pins(),
          {!adv, 1'b1, 1'b1, split ? 1'b1 : !incl_hi, fetch && !wr, 1'b1, 1'b1, 1'b0, 1'b0});
      chk("R2 R11 address on bus", pin_ad_o, caddr);
      pin_buswidth = bw;
      @(negedge clk);
      j = 0; fin = 0;
      while (!fin) begin
        chk("R4 R5 R7 R8 R10 strobe-phase pins", pins(),
            {1'b0, wr, split ? !(wr && llo) : !wr, split ? !(wr && lhi) : !incl_hi,
             fetch && !wr, wr, 1'b1, 1'b0, 1'b0});
        if (wr) begin
          b = (word && k == 1) ? req_wdata[15:8] : req_wdata[7:0];
          exp_ad = (word && bus16) ? req_wdata : {b, b};
          chk("R13 write lanes", pin_ad_o, exp_ad);
        end
        if (hmid && k == 0 && j == 0) pin_hold = 1;
        pin_ready = (j >= d);
        pin_ad_i = (k == 0) ? pat0 : pat1;
        fin = (j >= d) || (j == maxw);
        j++;
        @(negedge clk);
      end
      if (d > maxw) chk("R6 wait limit ends stretch", j, maxw + 1);
    end
    // completion clock: R2 R3 R12 R11
    chk("R2 done pulse idle pins", pins(),
        {adv, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1});
    if (!wr) begin
      if (word) exp_rd = bus16 ? pat0 : {pat1[7:0], pat0[7:0]};
      else exp_rd = {8'h00, (bus16 && a0) ? pat0[15:8] : pat0[7:0]};
      chk("R3 R11 R12 read result", req_rdata, exp_rd);
    end
    req_valid = 0;
    pin_ready = 1;
    @(negedge clk);
    if (hmid) begin
      chk("R10 hold granted after access", {pin_hlda, pin_ad_oe, pin_ctl_oe}, 3'b100);
      pin_hold = 0;
      @(negedge clk);
      chk("R9 hold released", {pin_hlda, pin_ctl_oe}, 2'b01);
    end else begin
      chk("R2 done lasts one clock", req_done, 1'b0);
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins", pins(), 9'b0_1_1_1_0_0_1_0_0);
    chk("R1 reset breq", pin_breq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // full configuration sweep
    for (int v = 0; v < 256; v++) begin
      do_access(v[7], v[6], v[5], v[4], v[3], v[2], v[1], v[0], v % 3, 3, 0,
                16'h4A30 + 16'(v * 6));
    end
    // wait limit sweep: ready held low past the limit
    for (int mw = 0; mw < 3; mw++) begin
      for (int dd = 0; dd < 4; dd++) begin
        do_access(1, 1, 0, 0, 1, 0, 0, 0, dd, mw, 0, 16'h1200);
        do_access(0, 0, 1, 1, 0, 1, 1, 0, dd, mw, 0, 16'h77F0);
      end
    end
    // hold while idle with pending request
    @(negedge clk);
    cfg_hold_en = 1; cfg_adv_mode = 0; pin_hold = 1;
    @(negedge clk);
    chk("R9 hold grant while idle", {pin_hlda, pin_ad_oe, pin_ctl_oe, pin_breq}, 4'b1000);
    req_valid = 1; req_word = 0; req_write = 0; req_addr = 16'h0100;
    @(negedge clk);
    chk("R9 breq while held", {pin_hlda, pin_breq, pin_astb, pin_rd_n}, 4'b1101);
    pin_hold = 0; req_valid = 0;
    @(negedge clk);
    chk("R9 bus returned", {pin_hlda, pin_breq, pin_ctl_oe}, 3'b001);
    // hold ignored when disabled
    cfg_hold_en = 0; pin_hold = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold ignored when disabled", {pin_hlda, pin_breq, pin_ctl_oe}, 3'b001);
    do_access(1, 0, 0, 0, 1, 1, 0, 0, 1, 3, 0, 16'h2222);
    pin_hold = 0;
    // hold raised during a stretched access
    cfg_hold_en = 1;
    do_access(1, 0, 1, 1, 1, 0, 0, 1, 2, 3, 1, 16'h3C3C);
    do_access(1, 1, 0, 0, 0, 1, 1, 0, 2, 3, 1, 16'h0F0F);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule